// File: doc/BRIEF.md
# Accumulator Machine Datapath

This block is the storage, arithmetic and bus fabric of a small 8-bit accumulator machine. It has an accumulator, a 5-bit instruction counter, a 5-bit memory address register, a memory buffer, an opcode register and a second-operand register. It also has an adder/subtracter, an incrementer for the instruction counter and a 32-byte memory whose lower half is writable and whose upper half is a fixed table. All of these meet on one shared 8-bit bus.

No sequencer is included. Every load, output-enable, memory and arithmetic control arrives directly on an input pin, the way a front panel of switches would drive it. A later control unit can take over these pins unchanged. An external byte input acts as one more bus source, so operands can be injected. Every register, the adder result and the bus are brought out for observation.

A floating bus has no two-state encoding. It is therefore shown as `bus_oe_o` low, with `bus_o` parked at zero.

Top module: `acc_dp_top`

## Requirements
- R1: While `rst_ni` is low, every register output (`a_o`, `ic_o`, `ma_o`, `mb_o`, `op_o`, `b_o`) reads 0, the writable memory half reads 0 and, with no source enabled, `bus_oe_o` is 0.
- R2: Registers change only on the falling edge of `clk_i`. A register whose load input is 0 keeps its value across that edge.
- R3: `alu_o` is computed from `a_o` (operand one) and `b_o` (operand two), modulo 256:
  - with both controls low it is the sum;
  - with `sub_b_i` high it is the difference;
  - with `zero_a_i` high it is `b_o`;
  - with both controls high it is `0 - b_o`.
- R4: With `ic_ld_i` and `ic_inc_i` high, each falling edge advances `ic_o` by one, wrapping from 31 to 0. With `ic_ld_i` high and `ic_inc_i` low, `ic_o` loads `bus_o[4:0]`.
- R5: `bus_o` carries the output of the single enabled source, and `bus_oe_o` is 1. The sources and their enables are:
  - `a_oe_i` for A;
  - `ic_oe_i` and `ma_oe_i` for IC and MA, zero-extended;
  - `mb_oe_i` for MB, `op_oe_i` for OP and `b_oe_i` for B;
  - `alu_oe_i` for the adder result;
  - `mem_rd_i` for memory data;
  - `ext_oe_i` for `ext_data_i`.

  With no source enabled, `bus_oe_o` is 0 and `bus_o` is 0.
- R6: With `mem_rd_i` high, `bus_o` shows the byte stored at address `ma_o`. Directly after reset this is address 0, which holds 0.
- R7: Addresses 16 to 31 are read-only. Address n reads `(n*29 + 53) mod 256`, and a write to one of them has no effect.
- R8: With `mem_wr_i` high and `ma_o` below 16, the falling edge stores `bus_o` at address `ma_o`. `ma_ld_i` loads `bus_o[4:0]` into `ma_o`.
- R9: At most one source enable is high in any cycle. This is an operating rule, and the checker watches for violations of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, falling edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ld_i | input | 1 | Load accumulator from bus |
| ic_ld_i | input | 1 | Load instruction counter |
| ic_inc_i | input | 1 | Counter load takes incremented value |
| ma_ld_i | input | 1 | Load address register from bus |
| mb_ld_i | input | 1 | Load memory buffer from bus |
| op_ld_i | input | 1 | Load opcode register from bus |
| b_ld_i | input | 1 | Load operand register from bus |
| a_oe_i | input | 1 | Accumulator drives bus |
| ic_oe_i | input | 1 | Instruction counter drives bus |
| ma_oe_i | input | 1 | Address register drives bus |
| mb_oe_i | input | 1 | Memory buffer drives bus |
| op_oe_i | input | 1 | Opcode register drives bus |
| b_oe_i | input | 1 | Operand register drives bus |
| alu_oe_i | input | 1 | Adder result drives bus |
| mem_rd_i | input | 1 | Memory drives bus |
| mem_wr_i | input | 1 | Store bus at address |
| ext_oe_i | input | 1 | External byte drives bus |
| ext_data_i | input | 8 | External byte |
| zero_a_i | input | 1 | Force adder operand one to zero |
| sub_b_i | input | 1 | Subtract operand two |
| a_o | output | 8 | Accumulator |
| ic_o | output | 5 | Instruction counter |
| ma_o | output | 5 | Memory address register |
| mb_o | output | 8 | Memory buffer |
| op_o | output | 8 | Opcode register |
| b_o | output | 8 | Operand register |
| alu_o | output | 8 | Adder/subtracter result |
| bus_o | output | 8 | Shared bus value |
| bus_oe_o | output | 1 | Bus is being driven |

## Verification
Each register is brought out directly, so a wrong load or a missed hold shows on its port right after the falling edge that caused it. An error in the counter wrap appears within 32 incrementing edges. A corrupted memory byte stays hidden until that address is selected with a read enabled. From then on it shows combinationally on `bus_o`, and it spreads into whichever register loads from the bus at the next falling edge. Adder faults show combinationally on `alu_o` as soon as A and B hold the offending operands.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned AW = 5;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF = DEPTH / 2;

  // bus source indices
  localparam int unsigned SRC_A   = 0;
  localparam int unsigned SRC_IC  = 1;
  localparam int unsigned SRC_MA  = 2;
  localparam int unsigned SRC_MB  = 3;
  localparam int unsigned SRC_OP  = 4;
  localparam int unsigned SRC_B   = 5;
  localparam int unsigned SRC_ALU = 6;
  localparam int unsigned SRC_MEM = 7;
  localparam int unsigned SRC_EXT = 8;
  localparam int unsigned NSRC    = 9;

  localparam logic [DW-1:0] ROM_MUL = DW'(29);
  localparam logic [DW-1:0] ROM_ADD = DW'(53);

  function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] addr);
    return DW'(DW'(addr) * ROM_MUL + ROM_ADD);
  endfunction
endpackage

// File: rtl/acc_dp_reg.sv
module acc_dp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_dp_addsub.sv
module acc_dp_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         zero_a_i,
  input  logic         sub_b_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] opa, opb;
  logic [W:0]   sum;

  always_comb begin
    opa = zero_a_i ? '0 : a_i;
    opb = sub_b_i ? ~b_i : b_i;
    sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, sub_b_i};
    s_o = sum[W-1:0]; // carry discarded
  end
endmodule

// File: rtl/acc_dp_mem.sv
module acc_dp_mem
  import acc_dp_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned A = AW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [A-1:0] addr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  localparam int unsigned NRAM = 1 << (A - 1);

  logic [W-1:0] ram_q   [NRAM];
  logic [W-1:0] rom_tab [NRAM];
  logic         in_ram;

  assign in_ram = ~addr_i[A-1];

  for (genvar g = 0; g < int'(NRAM); g++) begin : g_rom
    assign rom_tab[g] = W'(rom_byte(AW'(NRAM + g)));
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NRAM); i++) ram_q[i] <= '0;
    end else if (wr_i && in_ram) begin
      ram_q[addr_i[A-2:0]] <= wdata_i;
    end
  end

  assign rdata_o = in_ram ? ram_q[addr_i[A-2:0]] : rom_tab[addr_i[A-2:0]];
endmodule

// File: rtl/acc_dp_bus.sv
module acc_dp_bus #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 9
) (
  input  logic [N-1:0][W-1:0] src_data_i,
  input  logic [N-1:0]        src_en_i,
  output logic [W-1:0]        bus_o,
  output logic                drive_o
);
  // sources are mutually exclusive by rule; AND-OR keeps depth flat
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      bus_o |= src_data_i[i] & {W{src_en_i[i]}};
    end
    drive_o = |src_en_i;
  end
endmodule

// File: rtl/acc_dp_top.sv
module acc_dp_top
  import acc_dp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_ld_i,
  input  logic          ic_ld_i,
  input  logic          ic_inc_i,
  input  logic          ma_ld_i,
  input  logic          mb_ld_i,
  input  logic          op_ld_i,
  input  logic          b_ld_i,
  input  logic          a_oe_i,
  input  logic          ic_oe_i,
  input  logic          ma_oe_i,
  input  logic          mb_oe_i,
  input  logic          op_oe_i,
  input  logic          b_oe_i,
  input  logic          alu_oe_i,
  input  logic          mem_rd_i,
  input  logic          mem_wr_i,
  input  logic          ext_oe_i,
  input  logic [DW-1:0] ext_data_i,
  input  logic          zero_a_i,
  input  logic          sub_b_i,
  output logic [DW-1:0] a_o,
  output logic [AW-1:0] ic_o,
  output logic [AW-1:0] ma_o,
  output logic [DW-1:0] mb_o,
  output logic [DW-1:0] op_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] alu_o,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o
);
  logic [NSRC-1:0][DW-1:0] src_data;
  logic [NSRC-1:0]         src_en;
  logic [DW-1:0]           mem_rdata;
  logic [AW-1:0]           ic_d;

  always_comb begin
    src_data          = '0;
    src_data[SRC_A]   = a_o;
    src_data[SRC_IC]  = DW'(ic_o);
    src_data[SRC_MA]  = DW'(ma_o);
    src_data[SRC_MB]  = mb_o;
    src_data[SRC_OP]  = op_o;
    src_data[SRC_B]   = b_o;
    src_data[SRC_ALU] = alu_o;
    src_data[SRC_MEM] = mem_rdata;
    src_data[SRC_EXT] = ext_data_i;
  end

  assign src_en = {ext_oe_i, mem_rd_i, alu_oe_i, b_oe_i, op_oe_i,
                   mb_oe_i, ma_oe_i, ic_oe_i, a_oe_i};

  acc_dp_bus #(.W(DW), .N(NSRC)) u_bus (
    .src_data_i (src_data),
    .src_en_i   (src_en),
    .bus_o      (bus_o),
    .drive_o    (bus_oe_o)
  );

  acc_dp_addsub #(.W(DW)) u_alu (
    .a_i      (a_o),
    .b_i      (b_o),
    .zero_a_i (zero_a_i),
    .sub_b_i  (sub_b_i),
    .s_o      (alu_o)
  );

  assign ic_d = ic_inc_i ? ic_o + AW'(1) : bus_o[AW-1:0];

  acc_dp_reg #(.W(DW)) u_a  (.clk_i, .rst_ni, .ld_i(a_ld_i),  .d_i(bus_o),          .q_o(a_o));
  acc_dp_reg #(.W(AW)) u_ic (.clk_i, .rst_ni, .ld_i(ic_ld_i), .d_i(ic_d),           .q_o(ic_o));
  acc_dp_reg #(.W(AW)) u_ma (.clk_i, .rst_ni, .ld_i(ma_ld_i), .d_i(bus_o[AW-1:0]),  .q_o(ma_o));
  acc_dp_reg #(.W(DW)) u_mb (.clk_i, .rst_ni, .ld_i(mb_ld_i), .d_i(bus_o),          .q_o(mb_o));
  acc_dp_reg #(.W(DW)) u_op (.clk_i, .rst_ni, .ld_i(op_ld_i), .d_i(bus_o),          .q_o(op_o));
  acc_dp_reg #(.W(DW)) u_b  (.clk_i, .rst_ni, .ld_i(b_ld_i),  .d_i(bus_o),          .q_o(b_o));

  acc_dp_mem #(.W(DW), .A(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (ma_o),
    .wr_i    (mem_wr_i),
    .wdata_i (bus_o),
    .rdata_o (mem_rdata)
  );
endmodule

// File: rtl/acc_dp_chk.sv
module acc_dp_chk
  import acc_dp_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          a_ld_i,
  input logic          ic_ld_i,
  input logic          ic_inc_i,
  input logic          a_oe_i,
  input logic          ic_oe_i,
  input logic          ma_oe_i,
  input logic          mb_oe_i,
  input logic          op_oe_i,
  input logic          b_oe_i,
  input logic          alu_oe_i,
  input logic          mem_rd_i,
  input logic          ext_oe_i,
  input logic          zero_a_i,
  input logic          sub_b_i,
  input logic [DW-1:0] a_o,
  input logic [AW-1:0] ic_o,
  input logic [AW-1:0] ma_o,
  input logic [DW-1:0] mb_o,
  input logic [DW-1:0] op_o,
  input logic [DW-1:0] b_o,
  input logic          bus_oe_o
);
  logic [NSRC-1:0] en;
  assign en = {ext_oe_i, mem_rd_i, alu_oe_i, b_oe_i, op_oe_i,
               mb_oe_i, ma_oe_i, ic_oe_i, a_oe_i};

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (a_o == '0 && ic_o == '0 && ma_o == '0 &&
                                mb_o == '0 && op_o == '0 && b_o == '0);
    end
  end

  a_r2_hold_a: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !a_ld_i |=> a_o == $past(a_o));

  a_r3_sum_to_a: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (a_ld_i && alu_oe_i && !zero_a_i && !sub_b_i) |=>
      a_o == DW'($past(a_o) + $past(b_o)));

  a_r4_ic_step: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ic_ld_i && ic_inc_i) |=> ic_o == AW'($past(ic_o) + AW'(1)));

  a_r5_bus_idle: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !bus_oe_o);

  a_r9_one_source: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $countones(en) <= 1);
endmodule

bind acc_dp_top acc_dp_chk u_chk (.*);

// File: tb/acc_dp_top_tb.sv
module acc_dp_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic a_ld, ic_ld, ic_inc, ma_ld, mb_ld, op_ld, b_ld;
  logic a_oe, ic_oe, ma_oe, mb_oe, op_oe, b_oe, alu_oe, mem_rd, mem_wr, ext_oe;
  logic zero_a, sub_b;
  logic [7:0] ext_data;
  logic [7:0] a_o, mb_o, op_o, b_o, alu_o, bus_o;
  logic [4:0] ic_o, ma_o;
  logic bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_a, m_mb, m_op, m_b;
  logic [4:0] m_ic, m_ma;
  logic [7:0] m_ram [16];

  always #4 clk = ~clk;

  acc_dp_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_ld_i(a_ld), .ic_ld_i(ic_ld), .ic_inc_i(ic_inc), .ma_ld_i(ma_ld),
    .mb_ld_i(mb_ld), .op_ld_i(op_ld), .b_ld_i(b_ld),
    .a_oe_i(a_oe), .ic_oe_i(ic_oe), .ma_oe_i(ma_oe), .mb_oe_i(mb_oe),
    .op_oe_i(op_oe), .b_oe_i(b_oe), .alu_oe_i(alu_oe), .mem_rd_i(mem_rd),
    .mem_wr_i(mem_wr), .ext_oe_i(ext_oe), .ext_data_i(ext_data),
    .zero_a_i(zero_a), .sub_b_i(sub_b),
    .a_o(a_o), .ic_o(ic_o), .ma_o(ma_o), .mb_o(mb_o), .op_o(op_o), .b_o(b_o),
    .alu_o(alu_o), .bus_o(bus_o), .bus_oe_o(bus_oe)
  );

  function automatic logic [7:0] alu_ref(logic [7:0] a, logic [7:0] b, logic z, logic s);
    logic [7:0] x;
    x = z ? 8'd0 : a;
    return s ? 8'(x - b) : 8'(x + b);
  endfunction

  function automatic logic [7:0] mem_ref(logic [4:0] ad);
    if (ad >= 5'd16) return 8'(8'(ad) * 8'd29 + 8'd53);
    return m_ram[ad[3:0]];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    {a_ld, ic_ld, ic_inc, ma_ld, mb_ld, op_ld, b_ld} = '0;
    {a_oe, ic_oe, ma_oe, mb_oe, op_oe, b_oe, alu_oe, mem_rd, mem_wr, ext_oe} = '0;
    {zero_a, sub_b} = '0;
    ext_data = '0;
  endtask

  task automatic model_reset();
    m_a = 0; m_ic = 0; m_ma = 0; m_mb = 0; m_op = 0; m_b = 0;
    for (int i = 0; i < 16; i++) m_ram[i] = 0;
  endtask

  task automatic chk_regs(input string tag);
    chk(a_o, m_a, {tag, " A"});
    chk(8'(ic_o), 8'(m_ic), {tag, " IC"});
    chk(8'(ma_o), 8'(m_ma), {tag, " MA"});
    chk(mb_o, m_mb, {tag, " MB"});
    chk(op_o, m_op, {tag, " OP"});
    chk(b_o, m_b, {tag, " B"});
  endtask

  // src: 0 A,1 IC,2 MA,3 MB,4 OP,5 B,6 ALU,7 MEM,8 EXT,other none
  // ld bits [5:0]: A, IC, MA, MB, OP, B
  task automatic cycle(input int src, input logic [5:0] ld, input logic inc,
                       input logic z, input logic s, input logic wr,
                       input logic [7:0] ext);
    logic [7:0] eb;
    logic       eoe;
    idle_inputs();
    a_oe = (src == 0); ic_oe = (src == 1); ma_oe = (src == 2); mb_oe = (src == 3);
    op_oe = (src == 4); b_oe = (src == 5); alu_oe = (src == 6); mem_rd = (src == 7);
    ext_oe = (src == 8);
    {a_ld, ic_ld, ma_ld, mb_ld, op_ld, b_ld} = ld;
    ic_inc = inc; zero_a = z; sub_b = s; mem_wr = wr; ext_data = ext;
    #1;
    eoe = (src >= 0 && src <= 8);
    case (src)
      0: eb = m_a;
      1: eb = 8'(m_ic);
      2: eb = 8'(m_ma);
      3: eb = m_mb;
      4: eb = m_op;
      5: eb = m_b;
      6: eb = alu_ref(m_a, m_b, z, s);
      7: eb = mem_ref(m_ma);
      8: eb = ext;
      default: eb = 8'd0;
    endcase
    chk(bus_o, eb, src == 7 ? "R6 mem read" : "R5 bus value");
    chk(8'(bus_oe), 8'(eoe), "R5 bus drive");
    chk(alu_o, alu_ref(m_a, m_b, z, s), "R3 alu");
    // reference update (R2, R4, R8)
    if (wr && m_ma < 5'd16) m_ram[m_ma[3:0]] = eb;
    if (ld[5]) m_a = eb;
    if (ld[4]) m_ic = inc ? 5'(m_ic + 5'd1) : eb[4:0];
    if (ld[3]) m_ma = eb[4:0];
    if (ld[2]) m_mb = eb;
    if (ld[1]) m_op = eb;
    if (ld[0]) m_b = eb;
    @(negedge clk);
    #1;
    chk_regs("R2 R4 R8 regs");
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20071130));
    idle_inputs();
    model_reset();
    #1 rst_n = 1'b0;
    @(negedge clk); #1;
    chk_regs("R1 reset");
    chk(8'(bus_oe), 8'd0, "R1 bus idle");
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1;

    // R6: read after reset shows location 0
    cycle(7, 6'b000000, 0, 0, 0, 0, 8'h00);

    // R4: wrap 00..1f..00
    for (int i = 0; i < 32; i++) cycle(9, 6'b010000, 1, 0, 0, 0, 8'h00);
    chk(8'(ic_o), 8'h00, "R4 wrap to 00");
    cycle(8, 6'b010000, 0, 0, 0, 0, 8'hFD); // IC loads bus[4:0]=1d

    // R3 corners via ext loads
    cycle(8, 6'b100000, 0, 0, 0, 0, 8'h7F);
    cycle(8, 6'b000001, 0, 0, 0, 0, 8'h81);
    cycle(9, 6'b000000, 0, 0, 0, 0, 8'h00); // sum wraps to 00
    cycle(9, 6'b000000, 0, 0, 1, 0, 8'h00); // difference
    cycle(9, 6'b000000, 0, 1, 0, 0, 8'h00); // pass B
    cycle(9, 6'b000000, 0, 1, 1, 0, 8'h00); // negate B
    cycle(6, 6'b100000, 0, 0, 1, 0, 8'h00); // A <= A-B

    // R7/R8: write to ROM ignored, write to RAM stored
    cycle(8, 6'b001000, 0, 0, 0, 0, 8'h14);
    cycle(8, 6'b000000, 0, 0, 0, 1, 8'hAA);
    cycle(7, 6'b000100, 0, 0, 0, 0, 8'h00);
    chk(mb_o, 8'(8'd20 * 8'd29 + 8'd53), "R7 rom unchanged");
    cycle(8, 6'b001000, 0, 0, 0, 0, 8'h0F);
    cycle(8, 6'b000000, 0, 0, 0, 1, 8'h5C);
    cycle(7, 6'b000000, 0, 0, 0, 0, 8'h00);
    chk(bus_o, 8'h5C, "R8 ram stored");

    // R2 hold: no loads with active sources
    cycle(8, 6'b000000, 1, 1, 1, 0, 8'hEE);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      cycle(int'($urandom_range(0, 9)), 6'($urandom_range(0, 63)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            8'($urandom_range(0, 255)));
    end

    // R1: reset mid-run clears everything
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    #1;
    chk_regs("R1 async reset");
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++) begin
      cycle(8, 6'b001000, 0, 0, 0, 0, 8'(i));
      cycle(7, 6'b000000, 0, 0, 0, 0, 8'h00);
      chk(bus_o, 8'h00, "R1 ram cleared");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule